// File: doc/BRIEF.md
# Disk Task-File Status and Command Registers

This block is the device-side register slice of a parallel disk host interface. It keeps the command register and shows the device status byte to the host at two read addresses. The first is the primary status port, which shares its address with the command register in the command block. The second is a shadow copy in the control block. It also drives the interrupt request line to the host. When the host writes a command code, it sends a start pulse to the command engine.

The status byte is assembled from condition inputs that internal logic supplies: busy, ready, fault, seek complete, data request and error. An error flag means that the command just finished met an error; its cause is kept in a separate error register outside this block. The host must write all command parameters into their own registers before it writes the command code, because execution begins at once.

The interrupt line is set by a one-cycle completion pulse from the command engine. Only a read of the primary status port acknowledges the interrupt. A read of the shadow port returns the same byte and leaves the interrupt pending.

Top module: `tf_status_cmd`

## Requirements
- R1: The status byte holds error in bit 0, data request in bit 3, seek complete in bit 4, fault in bit 5, ready in bit 6 and busy in bit 7. Bits 1 and 2 always read 0.
- R2: When `rd_stb` is high, `cmd_cs` is high, `ctl_cs` is low and `reg_addr` is 7, `rd_data` shows the current status byte in the same cycle. This is the primary status read.
- R3: When `rd_stb` is high, `ctl_cs` is high, `cmd_cs` is low and `reg_addr` is 6, `rd_data` shows the same status byte in the same cycle. This is the shadow status read.
- R4: `rd_data` is 0x00 whenever neither R2 nor R3 applies. This covers no read strobe, any other address, both chip selects high, and neither chip select high.
- R5: A write strobe with `cmd_cs` high, `ctl_cs` low and `reg_addr` 7 stores `wr_data` as the command code. In the next cycle `start_o` is high for exactly one cycle and `code_o` equals that code. `code_o` then holds the code until the next command write.
- R6: Any other write (another address, the control block, both chip selects, or no strobe) raises no `start_o` and leaves `code_o` unchanged.
- R7: A high `done_i` sets `irq_o` in the next cycle.
- R8: A primary status read with `done_i` low clears `irq_o` in the next cycle.
- R9: A shadow status read leaves `irq_o` unchanged.
- R10: When `done_i` and a primary status read occur in the same cycle, `irq_o` is high in the next cycle.
- R11: The synchronous active-high `rst` clears `irq_o` and `code_o` and holds `start_o` low. Write strobes and `done_i` that arrive while `rst` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_cs | input | 1 | Command-block chip select |
| ctl_cs | input | 1 | Control-block chip select |
| reg_addr | input | 3 | Register index within the selected block |
| rd_stb | input | 1 | Single-cycle read strobe |
| wr_stb | input | 1 | Single-cycle write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data; 0x00 when nothing is mapped |
| busy_i | input | 1 | Device busy condition |
| ready_i | input | 1 | Device ready condition |
| fault_i | input | 1 | Device fault condition |
| seek_done_i | input | 1 | Seek complete condition |
| drq_i | input | 1 | Data request condition |
| err_i | input | 1 | Previous command ended in error |
| done_i | input | 1 | One-cycle command completion pulse |
| irq_o | output | 1 | Interrupt request to the host |
| start_o | output | 1 | One-cycle command start pulse |
| code_o | output | 8 | Last command code written |

## Verification
The key corner case is that two read ports return the same byte but only one of them acknowledges the interrupt. The bench sets the interrupt and reads the shadow port, which must leave it pending. A design that decodes the acknowledge from the status value, or from either address, would drop the interrupt on that read. The bench also makes a completion and an acknowledge arrive in the same cycle, where a design with the wrong priority would lose a fresh interrupt.

A second group of tests covers chip-select and address qualification. These are reads and writes with both chip selects high, with the wrong block selected, and at other indices. A loose decoder would issue stray start pulses, overwrite the code, or return status where 0x00 is expected. The last tests apply reset while a write and a completion are pending, which shows whether reset wins.

// File: rtl/tf_pkg.sv
package tf_pkg;
    localparam int STAT_W = 8;

    typedef struct packed {
        logic busy;
        logic ready;
        logic fault;
        logic seek;
        logic drq;
        logic err;
    } cond_t;

    typedef struct packed {
        logic pri_rd;
        logic alt_rd;
        logic cmd_wr;
    } acc_t;
endpackage

// File: rtl/tf_addr_decode.sv
module tf_addr_decode
    import tf_pkg::*;
#(
    parameter int            AW      = 3,
    parameter logic [AW-1:0] PRI_IDX = 3'd7,
    parameter logic [AW-1:0] ALT_IDX = 3'd6
) (
    input  logic          cmd_cs,
    input  logic          ctl_cs,
    input  logic [AW-1:0] reg_addr,
    input  logic          rd_stb,
    input  logic          wr_stb,
    output acc_t          acc
);
    logic only_cmd;
    logic only_ctl;

    always_comb begin
        only_cmd   = cmd_cs & ~ctl_cs;
        only_ctl   = ctl_cs & ~cmd_cs;
        acc.pri_rd = rd_stb & only_cmd & (reg_addr == PRI_IDX);
        acc.alt_rd = rd_stb & only_ctl & (reg_addr == ALT_IDX);
        acc.cmd_wr = wr_stb & only_cmd & (reg_addr == PRI_IDX);
    end
endmodule

// File: rtl/tf_status_pack.sv
module tf_status_pack
    import tf_pkg::*;
(
    input  cond_t              cond,
    output logic [STAT_W-1:0]  status
);
    // Bit positions are fixed by the host software that decodes this byte.
    always_comb begin
        status    = '0;
        status[7] = cond.busy;
        status[6] = cond.ready;
        status[5] = cond.fault;
        status[4] = cond.seek;
        status[3] = cond.drq;
        status[0] = cond.err;
    end
endmodule

// File: rtl/tf_irq_ctl.sv
module tf_irq_ctl (
    input  logic clk,
    input  logic rst,
    input  logic set_pulse,
    input  logic ack,
    output logic irq
);
    typedef struct packed {
        logic irq;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_pulse) begin
            st_d.irq = 1'b1;        // completion takes priority over acknowledge
        end else if (ack) begin
            st_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.irq;
endmodule

// File: rtl/tf_cmd_reg.sv
module tf_cmd_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [DW-1:0] wr_data,
    output logic          start,
    output logic [DW-1:0] code
);
    typedef struct packed {
        logic [DW-1:0] code;
        logic          start;
    } cmd_st_t;

    cmd_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.start = wr;
        if (wr) begin
            st_d.code = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign start = st_q.start;
    assign code  = st_q.code;
endmodule

// File: rtl/tf_status_cmd.sv
module tf_status_cmd
    import tf_pkg::*;
#(
    parameter int            AW      = 3,
    parameter logic [AW-1:0] PRI_IDX = 3'd7,
    parameter logic [AW-1:0] ALT_IDX = 3'd6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_cs,
    input  logic              ctl_cs,
    input  logic [AW-1:0]     reg_addr,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [STAT_W-1:0] wr_data,
    output logic [STAT_W-1:0] rd_data,
    input  logic              busy_i,
    input  logic              ready_i,
    input  logic              fault_i,
    input  logic              seek_done_i,
    input  logic              drq_i,
    input  logic              err_i,
    input  logic              done_i,
    output logic              irq_o,
    output logic              start_o,
    output logic [STAT_W-1:0] code_o
);
    acc_t              acc;
    cond_t             cond;
    logic [STAT_W-1:0] status;

    tf_addr_decode #(
        .AW      (AW),
        .PRI_IDX (PRI_IDX),
        .ALT_IDX (ALT_IDX)
    ) u_dec (
        .cmd_cs   (cmd_cs),
        .ctl_cs   (ctl_cs),
        .reg_addr (reg_addr),
        .rd_stb   (rd_stb),
        .wr_stb   (wr_stb),
        .acc      (acc)
    );

    always_comb begin
        cond.busy  = busy_i;
        cond.ready = ready_i;
        cond.fault = fault_i;
        cond.seek  = seek_done_i;
        cond.drq   = drq_i;
        cond.err   = err_i;
    end

    tf_status_pack u_pack (
        .cond   (cond),
        .status (status)
    );

    tf_irq_ctl u_irq (
        .clk       (clk),
        .rst       (rst),
        .set_pulse (done_i),
        .ack       (acc.pri_rd),
        .irq       (irq_o)
    );

    tf_cmd_reg #(
        .DW (STAT_W)
    ) u_cmd (
        .clk     (clk),
        .rst     (rst),
        .wr      (acc.cmd_wr),
        .wr_data (wr_data),
        .start   (start_o),
        .code    (code_o)
    );

    // Both status ports drive the same byte; only the decode differs.
    always_comb begin
        rd_data = '0;
        if (acc.pri_rd || acc.alt_rd) begin
            rd_data = status;
        end
    end
endmodule

// File: rtl/tf_status_cmd_chk.sv
module tf_status_cmd_chk #(
    parameter int            AW      = 3,
    parameter logic [AW-1:0] PRI_IDX = 3'd7,
    parameter logic [AW-1:0] ALT_IDX = 3'd6
) (
    input logic          clk,
    input logic          rst,
    input logic          cmd_cs,
    input logic          ctl_cs,
    input logic [AW-1:0] reg_addr,
    input logic          rd_stb,
    input logic          wr_stb,
    input logic [7:0]    wr_data,
    input logic [7:0]    rd_data,
    input logic          busy_i,
    input logic          ready_i,
    input logic          fault_i,
    input logic          seek_done_i,
    input logic          drq_i,
    input logic          err_i,
    input logic          done_i,
    input logic          irq_o,
    input logic          start_o,
    input logic [7:0]    code_o
);
    logic       pri;
    logic       alt;
    logic       wr7;
    logic [7:0] exp_stat;

    always_comb begin
        pri      = rd_stb && cmd_cs && !ctl_cs && (reg_addr == PRI_IDX);
        alt      = rd_stb && ctl_cs && !cmd_cs && (reg_addr == ALT_IDX);
        wr7      = wr_stb && cmd_cs && !ctl_cs && (reg_addr == PRI_IDX);
        exp_stat = {busy_i, ready_i, fault_i, seek_done_i, drq_i, 2'b00, err_i};
    end

    assert_zero_bits_R1: assert property (@(posedge clk) disable iff (rst)
        rd_data[2:1] == 2'b00);
    assert_pri_status_R2: assert property (@(posedge clk) disable iff (rst)
        pri |-> rd_data == exp_stat);
    assert_alt_status_R3: assert property (@(posedge clk) disable iff (rst)
        alt |-> rd_data == exp_stat);
    assert_unmapped_R4: assert property (@(posedge clk) disable iff (rst)
        !(pri || alt) |-> rd_data == 8'h00);
    assert_start_R5: assert property (@(posedge clk) disable iff (rst)
        wr7 |=> start_o && code_o == $past(wr_data));
    assert_no_start_R6: assert property (@(posedge clk) disable iff (rst)
        !wr7 |=> !start_o && $stable(code_o));
    assert_irq_set_R7: assert property (@(posedge clk) disable iff (rst)
        done_i |=> irq_o);
    assert_irq_ack_R8: assert property (@(posedge clk) disable iff (rst)
        pri && !done_i |=> !irq_o);
    assert_irq_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !pri && !done_i && irq_o |=> irq_o);
    assert_irq_cause_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(done_i));
endmodule

bind tf_status_cmd tf_status_cmd_chk #(
    .AW      (AW),
    .PRI_IDX (PRI_IDX),
    .ALT_IDX (ALT_IDX)
) u_chk (.*);

// File: tb/tf_status_cmd_test.sv
module tf_status_cmd_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_cs, ctl_cs, rd_stb, wr_stb;
    logic [2:0] reg_addr;
    logic [7:0] wr_data, rd_data, code_o;
    logic       busy_i, ready_i, fault_i, seek_done_i, drq_i, err_i, done_i;
    logic       irq_o, start_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;

    always #2.5 clk = ~clk;

    tf_status_cmd uut (
        .clk(clk), .rst(rst), .cmd_cs(cmd_cs), .ctl_cs(ctl_cs),
        .reg_addr(reg_addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .wr_data(wr_data), .rd_data(rd_data), .busy_i(busy_i),
        .ready_i(ready_i), .fault_i(fault_i), .seek_done_i(seek_done_i),
        .drq_i(drq_i), .err_i(err_i), .done_i(done_i), .irq_o(irq_o),
        .start_o(start_o), .code_o(code_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic idle();
        cmd_cs = 0; ctl_cs = 0; rd_stb = 0; wr_stb = 0;
        reg_addr = 0; wr_data = 0; done_i = 0;
    endtask

    task automatic set_cond(input logic [7:0] b);
        {busy_i, ready_i, fault_i, seek_done_i, drq_i} = b[7:3];
        err_i = b[0];
    endtask

    task automatic edge_step();
        @(negedge clk);
        #0.5;
    endtask

    task automatic pulse_done();
        idle(); done_i = 1;
        @(negedge clk); idle(); #0.5;
    endtask

    task automatic cmd_write(input logic [7:0] c);
        idle(); cmd_cs = 1; reg_addr = 3'd7; wr_stb = 1; wr_data = c;
        @(negedge clk); idle(); #0.5;
    endtask

    task automatic t_reset();
        chk("R11 reset irq", {7'd0, irq_o}, 8'h00);
        chk("R11 reset start", {7'd0, start_o}, 8'h00);
        chk("R11 reset code", code_o, 8'h00);
    endtask

    task automatic t_status_patterns();
        logic [7:0] pats [4] = '{8'hFF, 8'h00, 8'hA5, 8'h5A};
        foreach (pats[i]) begin
            set_cond(pats[i]);
            idle(); cmd_cs = 1; reg_addr = 3'd7; rd_stb = 1; #0.5;
            chk("R1 R2 primary status", rd_data, pats[i] & 8'hF9);
            idle(); ctl_cs = 1; reg_addr = 3'd6; rd_stb = 1; #0.5;
            chk("R3 shadow status", rd_data, pats[i] & 8'hF9);
            @(negedge clk);
        end
    endtask

    task automatic t_unmapped();
        set_cond(8'hFF);
        idle(); cmd_cs = 1; reg_addr = 3'd7; #0.5;
        chk("R4 no strobe", rd_data, 8'h00);
        idle(); cmd_cs = 1; reg_addr = 3'd6; rd_stb = 1; #0.5;
        chk("R4 cmd block idx6", rd_data, 8'h00);
        idle(); ctl_cs = 1; reg_addr = 3'd7; rd_stb = 1; #0.5;
        chk("R4 ctl block idx7", rd_data, 8'h00);
        idle(); cmd_cs = 1; ctl_cs = 1; reg_addr = 3'd7; rd_stb = 1; #0.5;
        chk("R4 both cs", rd_data, 8'h00);
        idle(); reg_addr = 3'd7; rd_stb = 1; #0.5;
        chk("R4 no cs", rd_data, 8'h00);
        @(negedge clk); idle();
    endtask

    task automatic t_command();
        cmd_write(8'hEC);
        chk("R5 start high", {7'd0, start_o}, 8'h01);
        chk("R5 code", code_o, 8'hEC);
        edge_step();
        chk("R5 start one cycle", {7'd0, start_o}, 8'h00);
        chk("R5 code held", code_o, 8'hEC);
        cmd_write(8'h20);
        cmd_write(8'h30);
        chk("R5 back to back start", {7'd0, start_o}, 8'h01);
        chk("R5 back to back code", code_o, 8'h30);
        edge_step();
    endtask

    task automatic t_stray_writes();
        idle(); cmd_cs = 1; reg_addr = 3'd2; wr_stb = 1; wr_data = 8'h11;
        edge_step();
        chk("R6 other idx start", {7'd0, start_o}, 8'h00);
        chk("R6 other idx code", code_o, 8'h30);
        idle(); ctl_cs = 1; reg_addr = 3'd7; wr_stb = 1; wr_data = 8'h22;
        edge_step();
        chk("R6 ctl block code", code_o, 8'h30);
        idle(); cmd_cs = 1; ctl_cs = 1; reg_addr = 3'd7; wr_stb = 1; wr_data = 8'h33;
        edge_step();
        chk("R6 both cs start", {7'd0, start_o}, 8'h00);
        chk("R6 both cs code", code_o, 8'h30);
        idle();
    endtask

    task automatic t_irq();
        pulse_done();
        chk("R7 irq set", {7'd0, irq_o}, 8'h01);
        idle(); ctl_cs = 1; reg_addr = 3'd6; rd_stb = 1;
        edge_step();
        chk("R9 shadow read keeps irq", {7'd0, irq_o}, 8'h01);
        idle(); cmd_cs = 1; ctl_cs = 1; reg_addr = 3'd7; rd_stb = 1;
        edge_step();
        chk("R4 both cs read keeps irq", {7'd0, irq_o}, 8'h01);
        idle(); cmd_cs = 1; reg_addr = 3'd7; rd_stb = 1;
        edge_step();
        chk("R8 primary read clears irq", {7'd0, irq_o}, 8'h00);
        idle();
        pulse_done();
        idle(); cmd_cs = 1; reg_addr = 3'd7; rd_stb = 1; done_i = 1;
        edge_step();
        chk("R10 completion wins", {7'd0, irq_o}, 8'h01);
        idle();
    endtask

    task automatic t_reset_priority();
        idle(); rst = 1; done_i = 1; cmd_cs = 1; reg_addr = 3'd7; wr_stb = 1; wr_data = 8'h99;
        edge_step();
        chk("R11 irq cleared", {7'd0, irq_o}, 8'h00);
        chk("R11 start suppressed", {7'd0, start_o}, 8'h00);
        chk("R11 code cleared", code_o, 8'h00);
        idle(); rst = 0;
        edge_step();
        chk("R11 no late start", {7'd0, start_o}, 8'h00);
    endtask

    initial begin
        int cyc = 0;
        while (!ended) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000 && !ended) begin
                ended = 1;
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=hung expected=done");
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin
        idle(); set_cond(8'h00); rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        edge_step();
        t_reset();
        t_status_patterns();
        t_unmapped();
        t_command();
        t_stray_writes();
        t_irq();
        t_reset_priority();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule